// File: doc/BRIEF.md
# Packed-Byte GF(2) Affine Transform Unit

The unit takes a packed vector of up to 512 bits, treats it as a row of bytes, and replaces each byte `x` with `M·x ⊕ c` over GF(2). `M` is an 8×8 bit matrix and `c` is an 8-bit constant. The matrix vector carries one 64-bit matrix for every 64-bit lane, and that matrix serves all eight data bytes of its lane. A broadcast select makes lane 0's matrix serve every lane. The constant is shared by the whole vector.

A per-byte write mask decides which bytes take the transformed value. A masked-off byte is either cleared or keeps the matching byte of a supplied old destination vector. A vector-length select limits the active width to 128, 256 or 512 bits, and every byte above that width is cleared. The datapath is combinational and ends in one output register, so a result appears one clock after its valid strobe.

Top module: `gfaff_unit`

## Requirements
- R1: Result bit i of a transformed byte is the XOR-reduction of (matrix byte 7−i AND the input byte), XORed with bit i of `affConst`. Matrix byte k occupies bits [8k+7:8k] of its 64-bit lane matrix.
- R2: With broadcast off, the matrix in bits [64j+63:64j] of `matVec` transforms the eight data bytes at bits [64j+63:64j] of `dataVec`.
- R3: The same `affConst` is applied to every byte position.
- R4: `vlenSel` encodes the active width. 0 selects 2 lanes (128 bits), 1 selects 4 lanes (256 bits), and 2 or 3 select 8 lanes (512 bits).
- R5: With `bcastSel` set, every lane uses `matVec[63:0]`.
- R6: Byte b of lane j takes its transformed value when `byteMask[8j+b]` is 1 or when `maskEn` is 0.
- R7: A masked-off byte is 0x00 when `zeroMode` is 1.
- R8: A masked-off byte equals the same byte of `oldDest` when `zeroMode` is 0.
- R9: Every result bit at or above the active width is 0, whatever the mask and mode.
- R10: `outValid` is `inValid` delayed by exactly one clock. `result` loads only in a cycle where `inValid` is 1 and holds otherwise.
- R11: A synchronous active-high `rst` clears `outValid` and `result`.
- R12: The identity matrix 0x0102040810204080 in every lane, with constant 0 and no mask, returns `dataVec` unchanged at the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands are valid this cycle |
| dataVec | input | 512 | Packed data bytes |
| matVec | input | 512 | One 64-bit bit-matrix per lane |
| affConst | input | 8 | Additive constant for every byte |
| vlenSel | input | 2 | Active width code |
| byteMask | input | 64 | One write-mask bit per byte |
| maskEn | input | 1 | 1 applies `byteMask`, 0 writes all active bytes |
| zeroMode | input | 1 | 1 clears masked-off bytes, 0 keeps `oldDest` |
| bcastSel | input | 1 | 1 uses lane 0's matrix for all lanes |
| oldDest | input | 512 | Prior destination value for merging |
| outValid | output | 1 | Result is valid |
| result | output | 512 | Registered transformed vector |

## Verification
Two functions can decide the same byte in one cycle. A byte above the active width may also be masked off in merging mode, so length truncation and merging both claim it, and truncation must win with a zero. The table runs merging at 128 and 256 bits with random masks and an `oldDest` that is never zero. The bit-level model in the bench expects zeros in the upper lanes, so a byte that leaks its old value from above the active width is reported.

// File: rtl/gfaff_pkg.sv
package gfaff_pkg;
  localparam int LANES_MAX      = 8;
  localparam int LANE_W         = 64;
  localparam int BYTE_W         = 8;
  localparam int BYTES_PER_LANE = LANE_W / BYTE_W;
  localparam int VEC_W          = LANES_MAX * LANE_W;
  localparam int MASK_W         = LANES_MAX * BYTES_PER_LANE;
  localparam int MIN_LANES      = 2;
  localparam int VSEL_W         = 2;

  // strobes handed from control to datapath
  typedef struct packed {
    logic                 capture;
    logic                 useBcast;
    logic                 maskEn;
    logic                 zeroMode;
    logic [LANES_MAX-1:0] laneActive;
  } strobeT;
endpackage

// File: rtl/gfaff_ctrl.sv
module gfaff_ctrl
  import gfaff_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [VSEL_W-1:0] vlenSel,
  input  logic              bcastSel,
  input  logic              maskEn,
  input  logic              zeroMode,
  output strobeT            strobe,
  output logic              outValid
);
  logic [LANES_MAX-1:0] laneActive;

  // lane l is active when l < MIN_LANES << vlenSel (saturating at LANES_MAX)
  generate
    for (genvar l = 0; l < LANES_MAX; l++) begin : g_lane
      always_comb laneActive[l] = (l < (MIN_LANES << vlenSel));
    end
  endgenerate

  always_comb begin
    strobe.capture    = inValid;
    strobe.useBcast   = bcastSel;
    strobe.maskEn     = maskEn;
    strobe.zeroMode   = zeroMode;
    strobe.laneActive = laneActive;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R11
  valid_reset_chk: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

// File: rtl/gfaff_datapath.sv
module gfaff_datapath
  import gfaff_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [VEC_W-1:0]  dataVec,
  input  logic [VEC_W-1:0]  matVec,
  input  logic [BYTE_W-1:0] affConst,
  input  logic [MASK_W-1:0] byteMask,
  input  logic [VEC_W-1:0]  oldDest,
  output logic [VEC_W-1:0]  result
);
  logic [VEC_W-1:0] nextResult;

  function automatic logic [BYTE_W-1:0] affineByte(
    input logic [LANE_W-1:0] mat,
    input logic [BYTE_W-1:0] x,
    input logic [BYTE_W-1:0] c);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++)
      r[i] = (^(mat[(BYTE_W-1-i)*BYTE_W +: BYTE_W] & x)) ^ c[i];
    return r;
  endfunction

  generate
    for (genvar l = 0; l < LANES_MAX; l++) begin : g_lane
      logic [LANE_W-1:0] laneMat;
      always_comb laneMat = strobe.useBcast ? matVec[LANE_W-1:0]
                                            : matVec[l*LANE_W +: LANE_W];
      for (genvar b = 0; b < BYTES_PER_LANE; b++) begin : g_byte
        localparam int POS = (l*BYTES_PER_LANE + b) * BYTE_W;
        logic [BYTE_W-1:0] aff;
        logic              writeIt;
        always_comb begin
          aff     = affineByte(laneMat, dataVec[POS +: BYTE_W], affConst);
          writeIt = !strobe.maskEn || byteMask[l*BYTES_PER_LANE + b];
          if (!strobe.laneActive[l])
            nextResult[POS +: BYTE_W] = '0;
          else if (writeIt)
            nextResult[POS +: BYTE_W] = aff;
          else if (strobe.zeroMode)
            nextResult[POS +: BYTE_W] = '0;
          else
            nextResult[POS +: BYTE_W] = oldDest[POS +: BYTE_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (strobe.capture) result <= nextResult;
  end

  // R11
  result_reset_chk: assert property (@(posedge clk)
    rst |=> (result == '0));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(result));
  // R7
  zero_all_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && strobe.maskEn && strobe.zeroMode && byteMask == '0)
      |=> (result == '0));
  // R8
  merge_all_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && strobe.maskEn && !strobe.zeroMode && byteMask == '0
     && (&strobe.laneActive)) |=> (result == $past(oldDest)));
  // R9
  top_lane_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !strobe.laneActive[LANES_MAX-1])
      |=> (result[VEC_W-1 -: LANE_W] == '0));
endmodule

// File: rtl/gfaff_unit.sv
module gfaff_unit
  import gfaff_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [VEC_W-1:0]  dataVec,
  input  logic [VEC_W-1:0]  matVec,
  input  logic [BYTE_W-1:0] affConst,
  input  logic [VSEL_W-1:0] vlenSel,
  input  logic [MASK_W-1:0] byteMask,
  input  logic              maskEn,
  input  logic              zeroMode,
  input  logic              bcastSel,
  input  logic [VEC_W-1:0]  oldDest,
  output logic              outValid,
  output logic [VEC_W-1:0]  result
);
  strobeT strobe;

  gfaff_ctrl i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .vlenSel(vlenSel),
    .bcastSel(bcastSel), .maskEn(maskEn), .zeroMode(zeroMode),
    .strobe(strobe), .outValid(outValid)
  );

  gfaff_datapath i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .dataVec(dataVec),
    .matVec(matVec), .affConst(affConst), .byteMask(byteMask),
    .oldDest(oldDest), .result(result)
  );
endmodule

// File: tb/test_gfaff_unit.sv
module test_gfaff_unit;
  localparam logic [63:0] IDENT = 64'h0102040810204080;
  // fields: [5:4] vlenSel, [3] broadcast, [2] maskEn, [1] zeroMode, [0] identity
  localparam int NCASE = 14;
  localparam logic [5:0] CASES [NCASE] = '{
    6'b10_0_0_0_0, 6'b01_0_0_0_0, 6'b00_0_0_0_0, 6'b10_1_0_0_0,
    6'b01_1_0_0_0, 6'b10_0_1_1_0, 6'b10_0_1_0_0, 6'b00_0_1_0_0,
    6'b01_0_1_0_0, 6'b01_1_1_1_0, 6'b00_1_1_0_0, 6'b11_0_1_0_0,
    6'b10_0_0_0_1, 6'b11_1_1_1_0
  };

  logic clk = 0, rst = 1, inValid = 0, maskEn = 0, zeroMode = 0, bcastSel = 0;
  logic [511:0] dataVec = '0, matVec = '0, oldDest = '0, result;
  logic [7:0] affConst = '0;
  logic [1:0] vlenSel = '0;
  logic [63:0] byteMask = '0;
  logic outValid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gfaff_unit i_gfaff_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .dataVec(dataVec),
    .matVec(matVec), .affConst(affConst), .vlenSel(vlenSel),
    .byteMask(byteMask), .maskEn(maskEn), .zeroMode(zeroMode),
    .bcastSel(bcastSel), .oldDest(oldDest), .outValid(outValid),
    .result(result)
  );

  function automatic logic [511:0] refModel();
    logic [511:0] r = '0;
    int lanes = (vlenSel == 2'd0) ? 2 : (vlenSel == 2'd1) ? 4 : 8;
    for (int j = 0; j < lanes; j++) begin
      logic [63:0] m = bcastSel ? matVec[63:0] : matVec[j*64 +: 64];
      for (int b = 0; b < 8; b++) begin
        logic [7:0] x = dataVec[j*64 + b*8 +: 8];
        logic [7:0] y;
        for (int row = 0; row < 8; row++) begin
          logic acc = affConst[row];
          for (int col = 0; col < 8; col++)
            acc = acc ^ (m[(7-row)*8 + col] & x[col]);
          y[row] = acc;
        end
        if (!maskEn || byteMask[j*8+b]) r[j*64+b*8 +: 8] = y;
        else if (!zeroMode) r[j*64+b*8 +: 8] = oldDest[j*64+b*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic checkVec(string req, logic [511:0] got, logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic randomize512(output logic [511:0] v);
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
  endtask

  task automatic fire();
    inValid = 1;
    @(negedge clk);
    inValid = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog got hung exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [511:0] exp, held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    checkVec("R11 result", result, '0);
    checkVec("R11 outValid", {511'b0, outValid}, '0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int t = 0; t < NCASE; t++) begin
      logic [5:0] c = CASES[t];
      vlenSel = c[5:4]; bcastSel = c[3]; maskEn = c[2]; zeroMode = c[1];
      randomize512(dataVec); randomize512(matVec); randomize512(oldDest);
      oldDest[7:0] = 8'hA5;
      affConst = 8'($urandom);
      byteMask = {$urandom, $urandom};
      if (c[0]) begin
        for (int j = 0; j < 8; j++) matVec[j*64 +: 64] = IDENT;
        affConst = 8'h00;
      end
      exp = refModel();
      fire();
      checkVec("R10 valid", {511'b0, outValid}, 512'd1);
      if (c[0]) checkVec("R12 identity", result, dataVec);
      else      checkVec("R1-table", result, exp);
    end

    // R9 merging at 128 bits with empty mask: upper lanes zero, low lanes old
    vlenSel = 2'd0; maskEn = 1; zeroMode = 0; bcastSel = 0; byteMask = '0;
    randomize512(oldDest); oldDest[511:128] = {384{1'b1}};
    exp = {384'b0, oldDest[127:0]};
    fire();
    checkVec("R9 truncate over merge", result, exp);
    checkVec("R8 merge low lanes", {384'b0, result[127:0]}, exp);

    // R10 hold when inValid low
    held = result;
    randomize512(dataVec); randomize512(oldDest); vlenSel = 2'd2; maskEn = 0;
    repeat (2) @(negedge clk);
    checkVec("R10 hold", result, held);
    checkVec("R10 valid low", {511'b0, outValid}, '0);

    // R3 constant only: zero matrix -> every active byte equals constant
    matVec = '0; affConst = 8'h3C; bcastSel = 0;
    fire();
    checkVec("R3 constant", result, {64{8'h3C}});

    // R5 broadcast: identity in lane 0 only, garbage elsewhere
    randomize512(matVec); matVec[63:0] = IDENT; affConst = 8'h00; bcastSel = 1;
    fire();
    checkVec("R5 broadcast", result, dataVec);

    // R11 reset after a result
    rst = 1;
    @(negedge clk);
    rst = 0;
    checkVec("R11 clear", result, '0);
    checkVec("R11 valid clear", {511'b0, outValid}, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule